// File: doc/BRIEF.md
# Power-Down Wake-Up Controller

This block puts a microcontroller core into power-down and brings it back out. When the core writes a 1 into the power-down bit of its power control register, the block drops the core clock enable on the next cycle and holds it low. An 8-bit wake mask picks which active-low interrupt lines may end power-down. That choice does not depend on the core's own interrupt enables, so a polling system can still be woken.

A line wakes the core when it is low and its mask bit is set. The lines first pass through a two-flop synchronizer. On wake-up the power-down bit clears at once. If the crystal was configured to halt during power-down, the clock enable then stays low until the oscillator-ready input goes high. Otherwise the clock enable returns on the same cycle that the power-down bit clears. A masked line that is already low when power-down is entered causes an immediate wake-up, so the core cannot lock up.

Top module: `pd_wake_ctrl`

## Requirements
- R1: After reset, `wake_mask` is 0, `pd_flag` is 0 and `core_clk_en` is 1.
- R2: A cycle with `wake_mask_wr` high loads `wake_mask_wdata` into `wake_mask`, which is visible after that clock edge.
- R3: A cycle in the running state with `pwr_ctl_wr` high and `pwr_ctl_pd_wdata` high sets `pd_flag` to 1 and `core_clk_en` to 0 after that edge.
- R4: Mask bit 0 selects line 0 (`irq_lines_n[0]`). Mask bit b, for b from 1 to 7, selects line b+1. Line 1 never wakes the core. A line wakes the core only while it is low and its mask bit is 1.
- R5: If a selected line is first sampled low at rising edge e, `pd_flag` is still 1 after edge e+1 and is 0 after edge e+2.
- R6: With `xtal_halts` low at wake-up, `core_clk_en` returns to 1 on the same edge at which `pd_flag` clears.
- R7: With `xtal_halts` high at wake-up, `core_clk_en` stays 0 until `osc_ready` is sampled high, and it is 1 after that edge.
- R8: If a selected line has been low for at least two cycles when power-down is entered at edge k, `pd_flag` is 1 after edge k and 0 after edge k+1.
- R9: With `wake_mask` zero, no line activity ends power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_ctl_wr | input | 1 | Write strobe for the power-down bit |
| pwr_ctl_pd_wdata | input | 1 | Value written to the power-down bit |
| wake_mask_wr | input | 1 | Write strobe for the wake mask |
| wake_mask_wdata | input | 8 | New wake mask value |
| irq_lines_n | input | 9 | Active-low interrupt lines 0 to 8 |
| xtal_halts | input | 1 | The crystal stops during power-down |
| osc_ready | input | 1 | The oscillator has restarted and settled |
| core_clk_en | output | 1 | Clock enable for the core |
| pd_flag | output | 1 | Power-down bit read-back |
| wake_mask | output | 8 | Current wake mask |

## Verification
A wrong mask-to-line mapping shows as a core that stays asleep, or wakes on the wrong line, two edges after that line falls. A missing or extra synchronizer stage moves the clear of `pd_flag` by one cycle. A state machine stuck in the settle state holds `core_clk_en` low after `osc_ready` rises. A skipped settle state raises `core_clk_en` while the crystal is still starting, on the same edge at which `pd_flag` clears. The bench sweeps every line against every single-bit mask, so each such fault appears in the first affected trial.

// File: rtl/pdw_pkg.sv
package pdw_pkg;
    localparam int MASK_W = 8;
    localparam int IRQ_W  = MASK_W + 1;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_SLEEP  = 2'd1,
        ST_SETTLE = 2'd2
    } pd_state_e;

    // Interrupt line served by mask bit b: bit 0 -> line 0, bit b -> line b+1
    function automatic int line_of_bit(input int b);
        return (b == 0) ? 0 : b + 1;
    endfunction

    // Active-high request per mask position from synchronized active-low lines
    function automatic logic [MASK_W-1:0] gather_active(input logic [IRQ_W-1:0] lines_n);
        logic [MASK_W-1:0] act;
        for (int b = 0; b < MASK_W; b++) begin
            act[b] = ~lines_n[line_of_bit(b)];
        end
        return act;
    endfunction
endpackage

// File: rtl/pdw_sync.sv
module pdw_sync #(
    parameter int W      = 9,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[0] <= '1;
                    else     stage_q[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '1;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/pdw_wake.sv
module pdw_wake
    import pdw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mask_wr,
    input  logic [MASK_W-1:0] mask_wdata,
    input  logic [IRQ_W-1:0]  lines_sync_n,
    output logic [MASK_W-1:0] mask_q,
    output logic              wake
);
    always_ff @(posedge clk) begin
        if (rst)          mask_q <= '0;
        else if (mask_wr) mask_q <= mask_wdata;
    end

    assign wake = |(mask_q & gather_active(lines_sync_n));

    // R1: mask clears on reset
    p_mask_reset_r1: assert property (@(posedge clk) rst |=> mask_q == '0);
    // R2: a write lands in the mask
    p_mask_load_r2: assert property (@(posedge clk) disable iff (rst)
        mask_wr |=> mask_q == $past(mask_wdata));
    // R9: an empty mask never raises a wake request
    p_no_wake_empty_r9: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |-> !wake);
endmodule

// File: rtl/pdw_fsm.sv
module pdw_fsm
    import pdw_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      enter_req,
    input  logic      wake,
    input  logic      xtal_halts,
    input  logic      osc_ready,
    output pd_state_e state
);
    pd_state_e state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:    if (enter_req) state_nx = ST_SLEEP;
            ST_SLEEP:  if (wake)      state_nx = xtal_halts ? ST_SETTLE : ST_RUN;
            ST_SETTLE: if (osc_ready) state_nx = ST_RUN;
            default:                  state_nx = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_RUN;
        else     state <= state_nx;
    end

    // R3: entry takes effect on the next edge
    p_enter_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && enter_req) |=> state == ST_SLEEP);
    // R4: no wake request keeps the core asleep
    p_sleep_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SLEEP && !wake) |=> state == ST_SLEEP);
    // R6: a running crystal skips the settle wait
    p_direct_run_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SLEEP && wake && !xtal_halts) |=> state == ST_RUN);
    // R7: settle wait holds until the oscillator is ready
    p_settle_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SETTLE && !osc_ready) |=> state == ST_SETTLE);
endmodule

// File: rtl/pd_wake_ctrl.sv
module pd_wake_ctrl
    import pdw_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_ctl_wr,
    input  logic              pwr_ctl_pd_wdata,
    input  logic              wake_mask_wr,
    input  logic [MASK_W-1:0] wake_mask_wdata,
    input  logic [IRQ_W-1:0]  irq_lines_n,
    input  logic              xtal_halts,
    input  logic              osc_ready,
    output logic              core_clk_en,
    output logic              pd_flag,
    output logic [MASK_W-1:0] wake_mask
);
    logic [IRQ_W-1:0] lines_sync_n;
    logic             wake;
    pd_state_e        state;

    pdw_sync #(.W(IRQ_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (irq_lines_n),
        .dout (lines_sync_n)
    );

    pdw_wake u_wake (
        .clk          (clk),
        .rst          (rst),
        .mask_wr      (wake_mask_wr),
        .mask_wdata   (wake_mask_wdata),
        .lines_sync_n (lines_sync_n),
        .mask_q       (wake_mask),
        .wake         (wake)
    );

    pdw_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .enter_req  (pwr_ctl_wr & pwr_ctl_pd_wdata),
        .wake       (wake),
        .xtal_halts (xtal_halts),
        .osc_ready  (osc_ready),
        .state      (state)
    );

    assign pd_flag     = (state == ST_SLEEP);
    assign core_clk_en = (state == ST_RUN);

    // R3: the core is never clocked while the power-down bit is set
    p_gate_in_pd_r3: assert property (@(posedge clk) disable iff (rst)
        pd_flag |-> !core_clk_en);
    // R1: reset state at the ports
    p_reset_ports_r1: assert property (@(posedge clk) rst |=> (core_clk_en && !pd_flag));
endmodule

// File: tb/tb_pd_wake_ctrl.sv
module tb_pd_wake_ctrl;
    logic       clk = 0;
    logic       rst;
    logic       pwr_ctl_wr, pwr_ctl_pd_wdata, wake_mask_wr;
    logic [7:0] wake_mask_wdata;
    logic [8:0] irq_lines_n;
    logic       xtal_halts, osc_ready;
    logic       core_clk_en, pd_flag;
    logic [7:0] wake_mask;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    pd_wake_ctrl dut (
        .clk(clk), .rst(rst),
        .pwr_ctl_wr(pwr_ctl_wr), .pwr_ctl_pd_wdata(pwr_ctl_pd_wdata),
        .wake_mask_wr(wake_mask_wr), .wake_mask_wdata(wake_mask_wdata),
        .irq_lines_n(irq_lines_n), .xtal_halts(xtal_halts), .osc_ready(osc_ready),
        .core_clk_en(core_clk_en), .pd_flag(pd_flag), .wake_mask(wake_mask)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1; cyc(2); rst = 0;
    endtask

    task automatic set_mask(input logic [7:0] m);
        wake_mask_wr = 1; wake_mask_wdata = m;
        cyc(1);
        wake_mask_wr = 0;
        chk("R2 mask load", wake_mask, m);
    endtask

    task automatic enter_pd();
        pwr_ctl_wr = 1; pwr_ctl_pd_wdata = 1;
        cyc(1);
        pwr_ctl_wr = 0; pwr_ctl_pd_wdata = 0;
    endtask

    // One line against one mask bit
    task automatic trial(input int line, input int b, input bit xt);
        bit hit;
        int mapped;
        mapped = (b == 0) ? 0 : b + 1;
        hit = (mapped == line);
        do_reset();
        irq_lines_n = '1; osc_ready = 0; xtal_halts = xt;
        set_mask(8'(1 << b));
        cyc(3);
        enter_pd();
        chk("R3 pd set", {7'd0, pd_flag}, 8'd1);
        chk("R3 clk gated", {7'd0, core_clk_en}, 8'd0);
        irq_lines_n[line] = 1'b0;
        cyc(2);
        chk("R5 still asleep after e+1", {7'd0, pd_flag}, 8'd1);
        cyc(1);
        chk("R4 wake decision", {7'd0, pd_flag}, {7'd0, !hit});
        if (hit && !xt)
            chk("R6 clk back with pd clear", {7'd0, core_clk_en}, 8'd1);
        else if (hit && xt) begin
            cyc(3);
            chk("R7 clk held while settling", {7'd0, core_clk_en}, 8'd0);
            osc_ready = 1;
            cyc(1);
            chk("R7 clk after osc ready", {7'd0, core_clk_en}, 8'd1);
        end else begin
            cyc(3);
            chk("R4 unselected line no wake", {7'd0, pd_flag}, 8'd1);
        end
        irq_lines_n = '1; osc_ready = 0;
    endtask

    initial begin
        rst = 1; pwr_ctl_wr = 0; pwr_ctl_pd_wdata = 0; wake_mask_wr = 0;
        wake_mask_wdata = 0; irq_lines_n = '1; xtal_halts = 0; osc_ready = 0;
        cyc(2); rst = 0;
        chk("R1 mask reset", wake_mask, 8'h00);
        chk("R1 pd reset", {7'd0, pd_flag}, 8'd0);
        chk("R1 clk_en reset", {7'd0, core_clk_en}, 8'd1);

        for (int line = 0; line < 9; line++)
            for (int b = 0; b < 8; b++)
                trial(line, b, 1'((line + b) % 2));

        // R9: empty mask, all lines low
        do_reset();
        set_mask(8'h00);
        enter_pd();
        irq_lines_n = '0;
        cyc(6);
        chk("R9 empty mask stays asleep", {7'd0, pd_flag}, 8'd1);
        irq_lines_n = '1;

        // R8: selected line already low at entry
        do_reset();
        xtal_halts = 0;
        set_mask(8'h80);
        irq_lines_n[8] = 1'b0;
        cyc(3);
        enter_pd();
        chk("R8 pd set at k", {7'd0, pd_flag}, 8'd1);
        cyc(1);
        chk("R8 immediate wake at k+1", {7'd0, pd_flag}, 8'd0);
        chk("R8 clk back", {7'd0, core_clk_en}, 8'd1);
        irq_lines_n = '1;

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule